// File: doc/BRIEF.md
# Priority-Encoded Jump Vector Register

This block holds the base address of a dispatch table used by an interrupt handler. Software writes the table base through a simple 16-bit register write strobe. A read returns an address, not the stored value. That address is the base plus an offset chosen by the most urgent of six pending ready flags, which come from the data-converter status logic. The handler can then branch straight to the matching table slot, without testing the flags one at a time.

Each slot spans four byte addresses, which is two 2-byte instruction words. The offset is therefore the index of the winning flag multiplied by four. Bit 0 of the stored base is always zero, so every returned address is word aligned. Flag 0 has the highest priority. The lookup is a single combinational encode-and-add on the flag state present in the read cycle. Its result is captured into the read-data register on that clock edge.

Top module: `jump_vector_reg`

## Requirements
- R1: A cycle with `wr_en` high loads the stored base from `wr_data`, with bit 0 forced to zero regardless of the written value.
- R2: After synchronous reset (`rst_n` low at a clock edge), the stored base and `rd_data` are both zero.
- R3: Input bit `ready[i]` is flag i. A read returns the base plus 4 × i, where i is the lowest-numbered set flag: flag 0 wins over all others and flag 5 loses to all others.
- R4: If no ready flag is set in the read cycle, the read returns the stored base alone.
- R5: The addition is 16 bits wide and wraps modulo 65536. For example, base 0xFFFE with only flag 5 set returns 0x0012.
- R6: `rd_data` updates on the clock edge that ends a cycle with `rd_en` high, using the flags in that cycle. While `rd_en` is low, `rd_data` holds its value even if the flags change.
- R7: When `wr_en` and `rd_en` are high in the same cycle, the read uses the base stored before that write.
- R8: Reading does not change the stored base, so repeated reads with unchanged flags return the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe that loads the base |
| wr_data | input | 16 | Base value to write (bit 0 ignored) |
| rd_en | input | 1 | Read strobe that captures a vector |
| ready | input | 6 | Pending ready flags, bit i = flag i |
| rd_data | output | 16 | Registered vector address |

## Verification
The lookup is tried with each ready flag alone, so that every slot offset is seen and a wrong scale or index shows up. It is also tried with several flags set at once, including all six and pairs that exclude flag 0, which tells correct priority apart from reverse or highest-bit encoding. Other cases cover no flags set, an odd write value, and a base near the top of the address range. These tell apart the empty case, the LSB masking and the 16-bit wrap. Finally, the bench changes the flags while no read is issued, and it strobes a read together with a write, which separates holding from tracking and old-base from new-base behaviour.

// File: rtl/jv_pkg.sv
// Shared sizing for the jump vector register.
// Assumes a byte-addressed table with two 2-byte words per slot.
package jv_pkg;
    localparam int DATA_W    = 16;
    localparam int NUM_FLAGS = 6;
    localparam int SLOT_SH   = 2;
    localparam int IDX_W     = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;
endpackage

// File: rtl/jv_prio_enc.sv
// Priority encoder: reports the index of the lowest-numbered set flag.
// Assumes flag 0 is most urgent; idx is zero and hit low when no flag is set.
module jv_prio_enc #(
    parameter int NUM_FLAGS = 6,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [IDX_W-1:0]     idx,
    output logic                 hit
);
    // Scan from least to most urgent so the most urgent set flag wins last.
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = NUM_FLAGS - 1; i >= 0; i--) begin
            if (flags[i]) begin
                idx = IDX_W'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/jv_base_reg.sv
// Table base storage with the alignment bit forced to zero.
// Assumes synchronous active-low reset to zero.
module jv_base_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] base_q
);
    localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(1);

    // Load the aligned base on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_en)
            base_q <= wr_data & ALIGN_MASK;
    end
endmodule

// File: rtl/jv_rdata_reg.sv
// Read-data capture: registers the computed vector when a read is strobed.
// Assumes the vector input is already settled within the strobe cycle.
module jv_rdata_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] vec,
    output logic [DATA_W-1:0] rd_data
);
    // Capture on read, otherwise hold the last returned vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= vec;
    end
endmodule

// File: rtl/jump_vector_reg.sv
// Jump vector register: a read returns the base plus a slot offset that is
// chosen by the most urgent ready flag. The lookup path is combinational
// and is registered once at the read-data output.
// Assumes the flags are synchronous to clk.
module jump_vector_reg
    import jv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [NUM_FLAGS-1:0] ready,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] base_q;
    logic [IDX_W-1:0]  win_idx;
    logic              win_hit;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] vec;

    jv_prio_enc #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_enc (
        .flags (ready),
        .idx   (win_idx),
        .hit   (win_hit)
    );

    jv_base_reg #(.DATA_W(DATA_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .base_q  (base_q)
    );

    // Scale the winning index to a slot offset and add it to the base (wraps).
    always_comb begin
        offset = win_hit ? (DATA_W'(win_idx) << SLOT_SH) : '0;
        vec    = base_q + offset;
    end

    jv_rdata_reg #(.DATA_W(DATA_W)) u_rdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .vec     (vec),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/jump_vector_reg_chk.sv
// Checker for jump_vector_reg, bound onto every instance.
module jump_vector_reg_chk
    import jv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [NUM_FLAGS-1:0] ready,
    input  logic [DATA_W-1:0]    base_q,
    input  logic [DATA_W-1:0]    rd_data
);
    // R1: write loads aligned base
    a_r1_write_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base_q == {$past(wr_data[DATA_W-1:1]), 1'b0});

    // R1: returned address is always word aligned
    a_r1_rd_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

    // R3: flag 0 wins and gives offset zero
    a_r3_flag0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready[0]) |=> rd_data == $past(base_q));

    // R3: flag 5 alone gives the last slot
    a_r3_flag5_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready == 6'b100000) |=> rd_data == $past(base_q) + 16'd20);

    // R4: no flags returns the base
    a_r4_empty_base: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready == '0) |=> rd_data == $past(base_q));

    // R6: no read, output holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R8: read alone leaves the base untouched
    a_r8_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> $stable(base_q));
endmodule

bind jump_vector_reg jump_vector_reg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .ready   (ready),
    .base_q  (base_q),
    .rd_data (rd_data)
);

// File: tb/jump_vector_reg_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with rd_data on every clock.
module jump_vector_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [5:0]  ready = '0;
    logic [15:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int m_base  = 0;
    int m_rd    = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    jump_vector_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .ready(ready), .rd_data(rd_data)
    );

    // Compare the output with the model value
    task automatic check(input string tag);
        n_tests++;
        if (rd_data !== 16'(m_rd)) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, 16'(m_rd));
        end
    endtask

    // One clock: drive at negedge, update model at posedge, sample after it
    task automatic step(input bit w, input int wd, input bit r,
                        input logic [5:0] f, input string tag);
        @(negedge clk);
        wr_en = w; wr_data = 16'(wd); rd_en = r; ready = f;
        @(posedge clk);
        if (r) begin
            int off;
            off = 0;
            for (int i = 5; i >= 0; i--) if (f[i]) off = i * 4;
            m_rd = (m_base + off) % 65536;
        end
        if (w) m_base = wd & 16'hFFFE;
        #1;
        check(tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset rd_data");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 1, 6'b0, "R2 reset base zero");
        step(1, 16'h1235, 0, 6'b0, "R1 odd write");
        step(0, 0, 1, 6'b0, "R1 R4 aligned base, no flags");
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, 6'(1 << i), $sformatf("R3 single flag %0d", i));
        step(0, 0, 1, 6'b111111, "R3 all flags");
        step(0, 0, 1, 6'b101100, "R3 flags 2,3,5");
        step(0, 0, 1, 6'b110000, "R3 flags 4,5");
        step(0, 0, 0, 6'b000001, "R6 hold on flag change");
        step(0, 0, 0, 6'b100000, "R6 hold no read");
        step(0, 0, 1, 6'b001000, "R6 capture strobe-cycle flags");
        step(0, 0, 1, 6'b001000, "R8 repeat read same");
        step(1, 16'hFFFF, 0, 6'b0, "R5 write top");
        step(0, 0, 1, 6'b100000, "R5 wrap flag5");
        step(0, 0, 1, 6'b000100, "R5 wrap flag2");
        step(1, 16'h4000, 1, 6'b000010, "R7 read with write uses old base");
        step(0, 0, 1, 6'b000010, "R7 new base after write");
        step(0, 0, 1, 6'b0, "R4 base only");
        for (int k = 0; k < 40; k++)
            step(k % 3 == 0, k * 1237, k % 2 == 0, 6'(k * 7), "R3 R6 mixed");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); m_base = 0; m_rd = 0; #1;
        check("R2 re-reset");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule